// File: doc/BRIEF.md
# Write-Protected Seconds Counter

This block keeps a 32-bit count of elapsed seconds. A one-cycle pulse on the tick input advances the count by one. After the all-ones value the count returns to zero. At reset the count is loaded from a seed input, so the surrounding system can restore a time value it saved earlier.

Software reaches the count through three 16-bit registers on a simple register bus. One register holds the upper half of the count and one holds the lower half. The third is a write-enable control whose read value is always zero.

Software cannot change the count by accident. It must first set the enable bit. It may then write the lower half as often as it likes; the enable stays set. Writing the upper half commits the new time and clears the enable. While the enable is clear, writes to either half have no effect.

The bus carries no handshake. A read returns data in the same cycle. A write takes effect on the clock edge at which select and write are both high.

Top module: `rtc_sec_top`

## Requirements
- R1: While reset is low, the count loads from `seed_i` and the write enable is cleared. The first bus reads after reset return the seed, and a write to either half made right after reset is ignored.
- R2: If `tick_i` is high on a clock edge and no accepted write to a half is present, the count rises by exactly one at that edge. If tick is low and no such write is present, the count holds.
- R3: A tick applied when the count is 0xFFFFFFFF wraps the count to 0x00000000.
- R4: Reads return data in the same cycle, with `reg_we_i` low:
  - offset 0x0 returns bits 31:16 of the count;
  - offset 0x4 returns bits 15:0 of the count;
  - offset 0x8 always returns 0x0000.
- R5: A write to offset 0x8 loads the write enable from bit 0 of `reg_wdata_i`. A 1 arms it and a 0 disarms it; all other data bits are ignored.
- R6: A write to offset 0x4 while the enable is armed replaces bits 15:0 of the count and leaves the enable armed.
- R7: A write to offset 0x0 while the enable is armed replaces bits 31:16 of the count and clears the enable.
- R8: Writes to offsets 0x0 and 0x4 while the enable is clear leave the count unchanged, apart from any tick in the same cycle. Reads never change the count.
- R9: When an accepted write to either half and a tick fall on the same edge, the write wins. The other half keeps its value and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_i | input | 32 | Count value loaded while reset is low |
| tick_i | input | 1 | One-cycle pulse, once per second |
| reg_sel_i | input | 1 | Register bus select |
| reg_we_i | input | 1 | Write strobe, qualified by select |
| reg_addr_i | input | 4 | Byte offset: 0x0 upper half, 0x4 lower half, 0x8 write enable |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid in the same cycle as select |

## Verification
The assertions assume the following about the inputs:
- the tick is a clean one-cycle enable that may arrive on any edge, including the edge of a bus write;
- bus inputs are stable around each rising edge;
- offsets other than 0x0, 0x4 and 0x8 have no write effect.

The stimulus follows these rules. It changes every input on the falling edge. It raises the tick at most one cycle at a time, and it combines the tick with armed and unarmed writes on purpose. It reads back through the combinational read path during the low half of the clock, so reads never overlap an update edge.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
  // byte offsets of the register file
  localparam int unsigned OFS_HI  = 'h0;
  localparam int unsigned OFS_LO  = 'h4;
  localparam int unsigned OFS_CTL = 'h8;

  typedef enum logic [1:0] {
    SLOT_HI,
    SLOT_LO,
    SLOT_CTL,
    SLOT_NONE
  } slot_e;
endpackage

// File: rtl/rtc_sec_decode.sv
module rtc_sec_decode
  import rtc_sec_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned HALF_W = CNT_W / 2
) (
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              wr_hi_o,
  output logic              wr_lo_o,
  output logic              wr_ctl_o,
  output logic [HALF_W-1:0] rdata_o
);
  slot_e slot;

  always_comb begin
    if (addr_i == ADDR_W'(OFS_HI))       slot = SLOT_HI;
    else if (addr_i == ADDR_W'(OFS_LO))  slot = SLOT_LO;
    else if (addr_i == ADDR_W'(OFS_CTL)) slot = SLOT_CTL;
    else                                 slot = SLOT_NONE;
  end

  assign wr_hi_o  = sel_i && we_i && (slot == SLOT_HI);
  assign wr_lo_o  = sel_i && we_i && (slot == SLOT_LO);
  assign wr_ctl_o = sel_i && we_i && (slot == SLOT_CTL);

  always_comb begin
    unique case (slot)
      SLOT_HI: rdata_o = cnt_i[CNT_W-1:HALF_W];
      SLOT_LO: rdata_o = cnt_i[HALF_W-1:0];
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_sec_wprot.sv
module rtc_sec_wprot (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hi_i,
  input  logic wr_lo_i,
  input  logic wr_ctl_i,
  input  logic ctl_bit_i,
  output logic armed_o,
  output logic load_hi_o,
  output logic load_lo_o
);
  logic armed_q;

  assign load_hi_o = wr_hi_i && armed_q;
  assign load_lo_o = wr_lo_i && armed_q;
  assign armed_o   = armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (wr_ctl_i) armed_q <= ctl_bit_i;
    else if (load_hi_o) armed_q <= 1'b0;
  end

  // R5: the control write sets the enable from data bit 0
  p_ctl_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl_i |=> armed_q == $past(ctl_bit_i));
  // R7: committing the upper half disarms the enable
  p_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi_i && armed_q |=> !armed_q);
  // R6: writing the lower half keeps the enable armed
  p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_i && armed_q |=> armed_q);
endmodule

// File: rtl/rtc_sec_count.sv
module rtc_sec_count #(
  parameter int unsigned CNT_W = 32,
  localparam int unsigned HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  seed_i,
  input  logic              tick_i,
  input  logic              load_hi_i,
  input  logic              load_lo_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= seed_i;
    else if (load_hi_i) cnt_q[CNT_W-1:HALF_W] <= wdata_i;
    else if (load_lo_i) cnt_q[HALF_W-1:0] <= wdata_i;
    else if (tick_i)    cnt_q <= cnt_q + ONE;
  end

  assign cnt_o = cnt_q;

  // R2: one tick, one step
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !load_hi_i && !load_lo_i |=> cnt_q - $past(cnt_q) == ONE);
  // R2: idle holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !load_hi_i && !load_lo_i |=> $stable(cnt_q));
  // R3: wrap to zero
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !load_hi_i && !load_lo_i && (&cnt_q) |=> cnt_q == '0);
  // R7: upper write lands, lower half untouched even with a tick (R9)
  p_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_hi_i |=> cnt_q[CNT_W-1:HALF_W] == $past(wdata_i)
                  && cnt_q[HALF_W-1:0] == $past(cnt_q[HALF_W-1:0]));
  // R6: lower write lands, upper half untouched even with a tick (R9)
  p_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_lo_i && !load_hi_i |=> cnt_q[HALF_W-1:0] == $past(wdata_i)
                  && cnt_q[CNT_W-1:HALF_W] == $past(cnt_q[CNT_W-1:HALF_W]));
endmodule

// File: rtl/rtc_sec_top.sv
module rtc_sec_top
  import rtc_sec_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  seed_i,
  input  logic              tick_i,
  input  logic              reg_sel_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [HALF_W-1:0] reg_wdata_i,
  output logic [HALF_W-1:0] reg_rdata_o
);
  logic             wr_hi, wr_lo, wr_ctl;
  logic             armed, load_hi, load_lo;
  logic [CNT_W-1:0] cnt;

  rtc_sec_decode #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_decode (
    .sel_i   (reg_sel_i),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .cnt_i   (cnt),
    .wr_hi_o (wr_hi),
    .wr_lo_o (wr_lo),
    .wr_ctl_o(wr_ctl),
    .rdata_o (reg_rdata_o)
  );

  rtc_sec_wprot u_wprot (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hi_i  (wr_hi),
    .wr_lo_i  (wr_lo),
    .wr_ctl_i (wr_ctl),
    .ctl_bit_i(reg_wdata_i[0]),
    .armed_o  (armed),
    .load_hi_o(load_hi),
    .load_lo_o(load_lo)
  );

  rtc_sec_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed_i   (seed_i),
    .tick_i   (tick_i),
    .load_hi_i(load_hi),
    .load_lo_i(load_lo),
    .wdata_i  (reg_wdata_i),
    .cnt_o    (cnt)
  );

  // R8: a write to a half while disarmed, with no tick, leaves the count alone
  p_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel_i && reg_we_i && !armed && !tick_i
    && (reg_addr_i == ADDR_W'(OFS_HI) || reg_addr_i == ADDR_W'(OFS_LO))
    |=> $stable(cnt));
endmodule

// File: tb/rtc_sec_top_tb_top.sv
module rtc_sec_top_tb_top;
  localparam logic [31:0] SEED_A = 32'h1234_FFFE;
  localparam logic [31:0] SEED_B = 32'hDEAD_BEEF;

  typedef struct packed {
    logic        sel;
    logic        we;
    logic [3:0]  addr;
    logic [15:0] data;
    logic        tick;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    {1'b0,1'b0,4'h0,16'h0000,1'b1,32'h1234_FFFF,4'd2}, // R2 step
    {1'b0,1'b0,4'h0,16'h0000,1'b1,32'h1235_0000,4'd2}, // R2 carry
    {1'b0,1'b0,4'h0,16'h0000,1'b0,32'h1235_0000,4'd2}, // R2 hold
    {1'b1,1'b1,4'h0,16'hAAAA,1'b0,32'h1235_0000,4'd8}, // R8 locked high
    {1'b1,1'b1,4'h4,16'h5555,1'b1,32'h1235_0001,4'd8}, // R8 locked low, tick counts
    {1'b1,1'b1,4'h8,16'h0001,1'b0,32'h1235_0001,4'd5}, // R5 arm
    {1'b1,1'b1,4'h4,16'hBEEF,1'b0,32'h1235_BEEF,4'd6}, // R6 low write
    {1'b1,1'b1,4'h4,16'hCAFE,1'b1,32'h1235_CAFE,4'd9}, // R9 write beats tick, R6 still armed
    {1'b1,1'b1,4'h0,16'hFFFF,1'b0,32'hFFFF_CAFE,4'd7}, // R7 commit
    {1'b1,1'b1,4'h4,16'h0000,1'b0,32'hFFFF_CAFE,4'd7}, // R7 disarmed now
    {1'b1,1'b1,4'h8,16'h0003,1'b0,32'hFFFF_CAFE,4'd5}, // R5 arm via bit 0
    {1'b1,1'b1,4'h8,16'h0002,1'b0,32'hFFFF_CAFE,4'd5}, // R5 bit 0 clear disarms
    {1'b1,1'b1,4'h0,16'h0000,1'b0,32'hFFFF_CAFE,4'd5}, // R5 ignored while disarmed
    {1'b1,1'b1,4'h8,16'h0001,1'b0,32'hFFFF_CAFE,4'd5}, // R5 arm
    {1'b1,1'b1,4'h4,16'hFFFF,1'b0,32'hFFFF_FFFF,4'd6}, // R6
    {1'b1,1'b1,4'h0,16'hFFFF,1'b1,32'hFFFF_FFFF,4'd9}, // R9 tick dropped on commit
    {1'b0,1'b0,4'h0,16'h0000,1'b1,32'h0000_0000,4'd3}, // R3 wrap
    {1'b1,1'b1,4'h8,16'h0001,1'b0,32'h0000_0000,4'd5}, // R5 arm
    {1'b1,1'b0,4'h0,16'h7777,1'b0,32'h0000_0000,4'd8}, // R8 read does not write
    {1'b1,1'b1,4'h0,16'h0001,1'b0,32'h0001_0000,4'd7}, // R7 still armed after read
    {1'b1,1'b1,4'h4,16'h1234,1'b0,32'h0001_0000,4'd7}  // R7 disarmed
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] seed = SEED_A;
  logic        tick = 1'b0;
  logic        sel = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_sec_top dut_i (
    .clk(clk), .rst_n(rst_n), .seed_i(seed), .tick_i(tick),
    .reg_sel_i(sel), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // R4: combinational read-back of both halves and the control slot
  task automatic read_all(input string tag, input logic [31:0] exp);
    sel = 1'b1; we = 1'b0;
    addr = 4'h0; #1 chk(tag, rdata, exp[31:16]);
    addr = 4'h4; #1 chk(tag, rdata, exp[15:0]);
    addr = 4'h8; #1 chk("R4 ctl read", rdata, 16'h0000);
    sel = 1'b0; addr = 4'h0;
  endtask

  task automatic op(input logic s, input logic w, input logic [3:0] a,
                    input logic [15:0] d, input logic t);
    @(negedge clk);
    sel = s; we = w; addr = a; wdata = d; tick = t;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; tick = 1'b0;
  endtask

  initial begin
    // R1: reset with tick high loads the seed
    tick = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; tick = 1'b0;
    read_all("R1 seed", SEED_A);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i].sel, VEC[i].we, VEC[i].addr, VEC[i].data, VEC[i].tick);
      read_all($sformatf("R%0d vec %0d", VEC[i].req, i), VEC[i].exp);
    end

    // R1: reset while armed, new seed, enable comes back cleared
    op(1'b1, 1'b1, 4'h8, 16'h0001, 1'b0);
    @(negedge clk); seed = SEED_B; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    read_all("R1 reseed", SEED_B);
    op(1'b1, 1'b1, 4'h4, 16'h0000, 1'b0);
    read_all("R1 disarmed", SEED_B);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule